// File: doc/BRIEF.md
# Shared Issue Slot Arbiter with In-Order Checker

This block decides, every cycle, which instructions may issue into a fixed pool of issue slots and functional units. Two sources compete for that pool: the out-of-order main pipeline, which offers a vector of issue requests each tagged with a unit class, and a small in-order checker window that holds already-completed instructions waiting to be executed a second time. The second execution is compared against the first, which is how transient errors are caught.

The main pipeline always wins. Its requests are resolved first, in request-index order, and a request that finds no free slot or unit is skipped without holding up the others. Whatever slots and units remain then go to the checker window. The checker issues strictly in program order from the head of its window, and the first entry that cannot issue stops every entry behind it. The checker reuses the physical registers read by the first execution, so it adds no register-file ports. The only extra storage it needs is the window itself. To keep the total number of entries feeding selection unchanged, the out-of-order queue is sized smaller by the window depth.

Integer and floating-point dividers are not pipelined. A unit that accepts a divide is held busy for the divide latency, and neither source can use it until that latency has passed. All grant decisions are made combinationally and registered, so the decisions for cycle t appear on the outputs in cycle t+1. A checker enable input can switch off all checker issue, leaving the main pipeline running unchecked.

Top module: `issue_share_arb`

## Requirements
- R1: The total number of granted main requests plus granted checker entries never exceeds SLOTS (default 8) in any cycle.
- R2: A grant goes only to a valid main request. Main requests are considered from index 0 upward, and a request refused for lack of a slot or unit does not stop a higher-index request from being granted.
- R3: Every main request is decided before any checker entry. The checker receives only the slots and units that the main requests left unused.
- R4: Each request carries a 2-bit class code at bits [2i+1:2i]: 0 = integer ALU, 1 = integer multiply/divide, 2 = FP add, 3 = FP multiply/divide. The default unit ids are 0–7 for ALUs, 8–9 for integer mul/div, 10–11 for FP add and 12–13 for FP mul/div. Each granted operation receives the lowest free id in its class, reported as 4 bits at [4i+3:4i], and no unit is given out twice in one cycle.
- R5: Checker grants always form a prefix starting at entry 0. The first entry that is invalid, finds no slot or finds no free unit blocks every younger entry.
- R6: A divide (div bit set) granted on a mul/div unit makes that unit unavailable for the following LAT-1 decisions: 18 for integer and 11 for FP with default parameters. Other units of the same class stay usable during that time.
- R7: While chk_en is low, no checker entry is granted, and main grants are unaffected.
- R8: Grant and unit outputs are registered and reflect the inputs of the previous cycle. Reset clears all outputs and all divider busy state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chk_en | input | 1 | Allows checker issue when high |
| main_req_vld | input | MAIN_REQS | Valid bit for each main request |
| main_req_cls | input | 2*MAIN_REQS | Class code for each main request |
| main_req_div | input | MAIN_REQS | Marks a main request as a non-pipelined divide |
| chk_vld | input | CHK_DEPTH | Valid bit for each window entry (entry 0 is oldest) |
| chk_cls | input | 2*CHK_DEPTH | Class code for each window entry |
| chk_div | input | CHK_DEPTH | Marks a window entry as a divide |
| main_gnt | output | MAIN_REQS | Registered grant for each main request |
| main_unit | output | UW*MAIN_REQS | Unit id assigned to each granted main request |
| chk_gnt | output | CHK_DEPTH | Registered grant for each window entry |
| chk_unit | output | UW*CHK_DEPTH | Unit id assigned to each granted window entry |

## Verification
The bound checker evaluates the following on every cycle:
- the slot cap;
- the prefix shape of checker grants;
- the absence of checker grants one cycle after chk_en is low;
- that main grants go only to requests that were valid;
- that no unit id is handed out twice.

Some behaviours depend on a history of requests and can only be shown by the bench's scenarios:
- main priority over the checker;
- lowest-id selection within a class;
- the exact length of the integer and FP divider busy windows;
- the release of a busy divider by reset.

// File: rtl/isarb_pkg.sv
package isarb_pkg;

   // Functional-unit class codes carried with each request
   typedef enum logic [1:0] {
      FU_ALU  = 2'd0,
      FU_IMD  = 2'd1,
      FU_FADD = 2'd2,
      FU_FMD  = 2'd3
   } fu_cls_e;

   localparam int unsigned CLS_W = 2;

endpackage

// File: rtl/isarb_busy.sv
// Busy tracker for one non-pipelined unit: a divide started at a grant
// decision blocks the unit for the next LAT-1 decisions.
module isarb_busy #(
   parameter int LAT = 19,
   localparam int CW = (LAT > 2) ? $clog2(LAT) : 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy
);

   logic [CW-1:0] remain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         remain <= '0;
      else if (start)
         remain <= CW'(LAT - 1);
      else if (remain != '0)
         remain <= remain - 1'b1;
   end

   assign busy = (remain != '0);

endmodule

// File: rtl/isarb_alloc.sv
// Combinational slot and unit allocation: main requests first (skip on
// refusal), then the checker window in order (stop on refusal).
module isarb_alloc
   import isarb_pkg::*;
#(
   parameter int SLOTS     = 8,
   parameter int MAIN_REQS = 8,
   parameter int CHK_DEPTH = 8,
   parameter int N_ALU     = 8,
   parameter int N_IMD     = 2,
   parameter int N_FADD    = 2,
   parameter int N_FMD     = 2,
   localparam int NU        = N_ALU + N_IMD + N_FADD + N_FMD,
   localparam int UW        = (NU > 1) ? $clog2(NU) : 1,
   localparam int IMD_BASE  = N_ALU,
   localparam int FADD_BASE = N_ALU + N_IMD,
   localparam int FMD_BASE  = N_ALU + N_IMD + N_FADD
) (
   input  logic [MAIN_REQS-1:0]       main_vld,
   input  logic [2*MAIN_REQS-1:0]     main_cls,
   input  logic [MAIN_REQS-1:0]       main_div,
   input  logic                       chk_en,
   input  logic [CHK_DEPTH-1:0]       chk_vld,
   input  logic [2*CHK_DEPTH-1:0]     chk_cls,
   input  logic [CHK_DEPTH-1:0]       chk_div,
   input  logic [NU-1:0]              unit_busy,
   output logic [MAIN_REQS-1:0]       main_gnt,
   output logic [UW*MAIN_REQS-1:0]    main_unit,
   output logic [CHK_DEPTH-1:0]       chk_gnt,
   output logic [UW*CHK_DEPTH-1:0]    chk_unit,
   output logic [NU-1:0]              div_start
);

   function automatic logic [1:0] unit_cls(input int u);
      if (u < IMD_BASE)       return FU_ALU;
      else if (u < FADD_BASE) return FU_IMD;
      else if (u < FMD_BASE)  return FU_FADD;
      else                    return FU_FMD;
   endfunction

   function automatic logic is_long(input logic [1:0] c);
      return (c == FU_IMD) || (c == FU_FMD);
   endfunction

   // Returns {found, id} of the lowest available unit of class c
   function automatic logic [UW:0] pick(input logic [1:0] c,
                                        input logic [NU-1:0] avail);
      logic [UW:0] r;
      r = '0;
      for (int u = NU - 1; u >= 0; u--) begin
         if (avail[u] && (unit_cls(u) == c))
            r = {1'b1, UW'(u)};
      end
      return r;
   endfunction

   always_comb begin
      logic [NU-1:0] taken;
      logic [UW:0]   pk;
      logic [1:0]    cls;
      logic          stop;
      int            used;

      taken     = '0;
      used      = 0;
      main_gnt  = '0;
      main_unit = '0;
      chk_gnt   = '0;
      chk_unit  = '0;
      div_start = '0;

      // Main pipeline: static priority, refusal skips to next request
      for (int i = 0; i < MAIN_REQS; i++) begin
         cls = main_cls[2*i +: 2];
         pk  = pick(cls, ~taken & ~unit_busy);
         if (main_vld[i] && (used < SLOTS) && pk[UW]) begin
            main_gnt[i]            = 1'b1;
            main_unit[UW*i +: UW]  = pk[UW-1:0];
            taken[pk[UW-1:0]]      = 1'b1;
            used                   = used + 1;
            if (main_div[i] && is_long(cls))
               div_start[pk[UW-1:0]] = 1'b1;
         end
      end

      // Checker window: leftovers only, strict program order
      stop = !chk_en;
      for (int j = 0; j < CHK_DEPTH; j++) begin
         cls = chk_cls[2*j +: 2];
         pk  = pick(cls, ~taken & ~unit_busy);
         if (!stop) begin
            if (chk_vld[j] && (used < SLOTS) && pk[UW]) begin
               chk_gnt[j]            = 1'b1;
               chk_unit[UW*j +: UW]  = pk[UW-1:0];
               taken[pk[UW-1:0]]     = 1'b1;
               used                  = used + 1;
               if (chk_div[j] && is_long(cls))
                  div_start[pk[UW-1:0]] = 1'b1;
            end else begin
               stop = 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/issue_share_arb.sv
module issue_share_arb
   import isarb_pkg::*;
#(
   parameter int SLOTS       = 8,
   parameter int MAIN_REQS   = 8,
   parameter int CHK_DEPTH   = 8,
   parameter int N_ALU       = 8,
   parameter int N_IMD       = 2,
   parameter int N_FADD      = 2,
   parameter int N_FMD       = 2,
   parameter int IDIV_LAT    = 19,
   parameter int FDIV_LAT    = 12,
   parameter int OOQ_ENTRIES = 120,
   parameter int SEL_BUDGET  = 128,
   localparam int NU = N_ALU + N_IMD + N_FADD + N_FMD,
   localparam int UW = (NU > 1) ? $clog2(NU) : 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    chk_en,
   input  logic [MAIN_REQS-1:0]    main_req_vld,
   input  logic [2*MAIN_REQS-1:0]  main_req_cls,
   input  logic [MAIN_REQS-1:0]    main_req_div,
   input  logic [CHK_DEPTH-1:0]    chk_vld,
   input  logic [2*CHK_DEPTH-1:0]  chk_cls,
   input  logic [CHK_DEPTH-1:0]    chk_div,
   output logic [MAIN_REQS-1:0]    main_gnt,
   output logic [UW*MAIN_REQS-1:0] main_unit,
   output logic [CHK_DEPTH-1:0]    chk_gnt,
   output logic [UW*CHK_DEPTH-1:0] chk_unit
);

   localparam int IMD_BASE  = N_ALU;
   localparam int FADD_BASE = N_ALU + N_IMD;
   localparam int FMD_BASE  = N_ALU + N_IMD + N_FADD;

   // Elaboration-time parameter checks
   if (OOQ_ENTRIES + CHK_DEPTH != SEL_BUDGET) begin : g_err_budget
      $error("queue plus checker window must equal selection budget");
   end
   if (SLOTS < 1 || MAIN_REQS < 1 || CHK_DEPTH < 1) begin : g_err_size
      $error("slot, request and window counts must be positive");
   end
   if (N_ALU < 1 || N_IMD < 1 || N_FADD < 1 || N_FMD < 1) begin : g_err_units
      $error("every unit class needs at least one unit");
   end
   if (IDIV_LAT < 2 || FDIV_LAT < 2) begin : g_err_lat
      $error("divide latencies must be at least 2");
   end

   logic [NU-1:0]              unit_busy;
   logic [NU-1:0]              div_start;
   logic [MAIN_REQS-1:0]       main_gnt_c;
   logic [UW*MAIN_REQS-1:0]    main_unit_c;
   logic [CHK_DEPTH-1:0]       chk_gnt_c;
   logic [UW*CHK_DEPTH-1:0]    chk_unit_c;

   isarb_alloc #(
      .SLOTS     (SLOTS),
      .MAIN_REQS (MAIN_REQS),
      .CHK_DEPTH (CHK_DEPTH),
      .N_ALU     (N_ALU),
      .N_IMD     (N_IMD),
      .N_FADD    (N_FADD),
      .N_FMD     (N_FMD)
   ) i_alloc (
      .main_vld  (main_req_vld),
      .main_cls  (main_req_cls),
      .main_div  (main_req_div),
      .chk_en    (chk_en),
      .chk_vld   (chk_vld),
      .chk_cls   (chk_cls),
      .chk_div   (chk_div),
      .unit_busy (unit_busy),
      .main_gnt  (main_gnt_c),
      .main_unit (main_unit_c),
      .chk_gnt   (chk_gnt_c),
      .chk_unit  (chk_unit_c),
      .div_start (div_start)
   );

   // Per-unit busy state: only the mul/div classes hold a divider
   for (genvar u = 0; u < NU; u++) begin : g_unit
      if (u >= IMD_BASE && u < FADD_BASE) begin : g_idiv
         isarb_busy #(.LAT(IDIV_LAT)) i_busy (
            .clk   (clk),
            .rst_n (rst_n),
            .start (div_start[u]),
            .busy  (unit_busy[u])
         );
      end else if (u >= FMD_BASE) begin : g_fdiv
         isarb_busy #(.LAT(FDIV_LAT)) i_busy (
            .clk   (clk),
            .rst_n (rst_n),
            .start (div_start[u]),
            .busy  (unit_busy[u])
         );
      end else begin : g_pipe
         logic unused_start;
         assign unused_start  = div_start[u];
         assign unit_busy[u]  = 1'b0;
      end
   end

   // Registered grants for the next stage
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         main_gnt  <= '0;
         main_unit <= '0;
         chk_gnt   <= '0;
         chk_unit  <= '0;
      end else begin
         main_gnt  <= main_gnt_c;
         main_unit <= main_unit_c;
         chk_gnt   <= chk_gnt_c;
         chk_unit  <= chk_unit_c;
      end
   end

endmodule

// File: rtl/isarb_sva.sv
module isarb_sva #(
   parameter int SLOTS     = 8,
   parameter int MAIN_REQS = 8,
   parameter int CHK_DEPTH = 8,
   parameter int NU        = 14,
   parameter int UW        = 4
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    chk_en,
   input logic [MAIN_REQS-1:0]    main_req_vld,
   input logic [MAIN_REQS-1:0]    main_gnt,
   input logic [UW*MAIN_REQS-1:0] main_unit,
   input logic [CHK_DEPTH-1:0]    chk_gnt,
   input logic [UW*CHK_DEPTH-1:0] chk_unit
);

   logic dup;

   always_comb begin
      logic [NU-1:0] seen;
      seen = '0;
      dup  = 1'b0;
      for (int i = 0; i < MAIN_REQS; i++) begin
         if (main_gnt[i]) begin
            if (seen[main_unit[UW*i +: UW]]) dup = 1'b1;
            seen[main_unit[UW*i +: UW]] = 1'b1;
         end
      end
      for (int j = 0; j < CHK_DEPTH; j++) begin
         if (chk_gnt[j]) begin
            if (seen[chk_unit[UW*j +: UW]]) dup = 1'b1;
            seen[chk_unit[UW*j +: UW]] = 1'b1;
         end
      end
   end

   a_r1_slot_cap : assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(main_gnt) + $countones(chk_gnt)) <= SLOTS);

   a_r2_valid_only : assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((main_gnt & ~$past(main_req_vld)) == '0));

   a_r4_unit_unique : assert property (@(posedge clk) disable iff (!rst_n)
      !dup);

   a_r5_chk_prefix : assert property (@(posedge clk) disable iff (!rst_n)
      ((chk_gnt & (chk_gnt + 1'b1)) == '0));

   a_r7_chk_off : assert property (@(posedge clk) disable iff (!rst_n)
      !chk_en |=> (chk_gnt == '0));

endmodule

bind issue_share_arb isarb_sva #(
   .SLOTS     (SLOTS),
   .MAIN_REQS (MAIN_REQS),
   .CHK_DEPTH (CHK_DEPTH),
   .NU        (NU),
   .UW        (UW)
) i_isarb_sva (
   .clk          (clk),
   .rst_n        (rst_n),
   .chk_en       (chk_en),
   .main_req_vld (main_req_vld),
   .main_gnt     (main_gnt),
   .main_unit    (main_unit),
   .chk_gnt      (chk_gnt),
   .chk_unit     (chk_unit)
);

// File: tb/test_issue_share_arb.sv
module test_issue_share_arb;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        chk_en;
   logic [7:0]  main_req_vld;
   logic [15:0] main_req_cls;
   logic [7:0]  main_req_div;
   logic [7:0]  chk_vld;
   logic [15:0] chk_cls;
   logic [7:0]  chk_div;
   logic [7:0]  main_gnt;
   logic [31:0] main_unit;
   logic [7:0]  chk_gnt;
   logic [31:0] chk_unit;

   int n_cmp = 0;
   int n_bad = 0;

   always #10 clk = ~clk;   // 50 MHz

   issue_share_arb i_issue_share_arb (
      .clk          (clk),
      .rst_n        (rst_n),
      .chk_en       (chk_en),
      .main_req_vld (main_req_vld),
      .main_req_cls (main_req_cls),
      .main_req_div (main_req_div),
      .chk_vld      (chk_vld),
      .chk_cls      (chk_cls),
      .chk_div      (chk_div),
      .main_gnt     (main_gnt),
      .main_unit    (main_unit),
      .chk_gnt      (chk_gnt),
      .chk_unit     (chk_unit)
   );

   typedef struct packed {
      logic [3:0]  rq;
      logic        en;
      logic [7:0]  mv;
      logic [15:0] mc;
      logic [7:0]  cv;
      logic [15:0] cc;
      logic [7:0]  emg;
      logic [7:0]  ecg;
   } vec_t;

   localparam int NV = 10;
   localparam vec_t VECS [NV] = '{
      '{4'd1, 1'b1, 8'hFF, 16'h0000, 8'hFF, 16'h0000, 8'hFF, 8'h00}, // R1 main fills all slots
      '{4'd1, 1'b1, 8'h0F, 16'h0000, 8'hFF, 16'h0000, 8'h0F, 8'h0F}, // R1 checker takes the rest
      '{4'd5, 1'b1, 8'h03, 16'h0005, 8'h03, 16'h0001, 8'h03, 8'h00}, // R5 head finds no unit
      '{4'd2, 1'b1, 8'h07, 16'h0015, 8'h00, 16'h0000, 8'h03, 8'h00}, // R2 third mul refused
      '{4'd2, 1'b1, 8'h0F, 16'h0015, 8'h00, 16'h0000, 8'h0B, 8'h00}, // R2 refusal skips
      '{4'd7, 1'b0, 8'h01, 16'h0000, 8'hFF, 16'h0000, 8'h01, 8'h00}, // R7 checker disabled
      '{4'd5, 1'b1, 8'h00, 16'h0000, 8'h0D, 16'h0000, 8'h00, 8'h01}, // R5 invalid entry blocks
      '{4'd3, 1'b1, 8'h01, 16'h0002, 8'h0F, 16'h003A, 8'h01, 8'h01}, // R3 leftover FP add
      '{4'd4, 1'b1, 8'h00, 16'h0000, 8'h07, 16'h003F, 8'h00, 8'h03}, // R4 two FP mul/div units
      '{4'd1, 1'b1, 8'h3F, 16'h0000, 8'hFF, 16'h0000, 8'h3F, 8'h03}  // R1 two slots left
   };

   task automatic check(input string rq, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
      end
   endtask

   task automatic drive(input logic en, input logic [7:0] mv, input logic [15:0] mc,
                        input logic [7:0] md, input logic [7:0] cv,
                        input logic [15:0] cc, input logic [7:0] cd);
      chk_en       = en;
      main_req_vld = mv;
      main_req_cls = mc;
      main_req_div = md;
      chk_vld      = cv;
      chk_cls      = cc;
      chk_div      = cd;
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      rst_n = 1'b0;
      drive(1'b1, 8'hFF, 16'h0000, 8'h00, 8'hFF, 16'h0000, 8'h00);
      repeat (3) @(negedge clk);
      // R8: nothing granted while in reset
      check("R8", "reset main_gnt", {24'h0, main_gnt}, 32'h0);
      check("R8", "reset chk_gnt", {24'h0, chk_gnt}, 32'h0);
      check("R8", "reset main_unit", main_unit, 32'h0);
      drive(1'b1, 8'h00, 16'h0000, 8'h00, 8'h00, 16'h0000, 8'h00);
      rst_n = 1'b1;

      // Vector table
      for (int k = 0; k < NV; k++) begin
         @(negedge clk);
         drive(VECS[k].en, VECS[k].mv, VECS[k].mc, 8'h00, VECS[k].cv, VECS[k].cc, 8'h00);
         @(negedge clk);
         check($sformatf("R%0d", VECS[k].rq), $sformatf("vec %0d main_gnt", k),
               {24'h0, main_gnt}, {24'h0, VECS[k].emg});
         check($sformatf("R%0d", VECS[k].rq), $sformatf("vec %0d chk_gnt", k),
               {24'h0, chk_gnt}, {24'h0, VECS[k].ecg});
      end

      // R4: lowest free unit id per class
      drive(1'b1, 8'h1F, 16'h00E4, 8'h00, 8'h01, 16'h0001, 8'h00);
      @(negedge clk);
      check("R4", "main_gnt", {24'h0, main_gnt}, 32'h1F);
      check("R4", "main_unit", main_unit, 32'h0001_CA80);
      check("R4", "chk_gnt", {24'h0, chk_gnt}, 32'h01);
      check("R4", "chk_unit", chk_unit, 32'h9);

      // R8: one-cycle registered latency
      drive(1'b1, 8'h00, 16'h0000, 8'h00, 8'h00, 16'h0000, 8'h00);
      @(negedge clk);
      check("R8", "idle main_gnt", {24'h0, main_gnt}, 32'h0);
      drive(1'b1, 8'h01, 16'h0000, 8'h00, 8'h00, 16'h0000, 8'h00);
      #1;
      check("R8", "before edge", {24'h0, main_gnt}, 32'h0);
      @(negedge clk);
      check("R8", "after edge", {24'h0, main_gnt}, 32'h01);

      // R6: integer divide holds unit 8 for 18 decisions
      drive(1'b1, 8'h01, 16'h0001, 8'h01, 8'h00, 16'h0000, 8'h00);
      @(negedge clk);
      check("R6", "idiv unit", main_unit, 32'h8);
      drive(1'b1, 8'h03, 16'h0005, 8'h00, 8'h00, 16'h0000, 8'h00);
      for (int k = 1; k <= 18; k++) begin
         @(negedge clk);
         check("R6", $sformatf("idiv busy %0d gnt", k), {24'h0, main_gnt}, 32'h01);
         check("R6", $sformatf("idiv busy %0d unit", k), main_unit, 32'h9);
      end
      @(negedge clk);
      check("R6", "idiv released gnt", {24'h0, main_gnt}, 32'h03);
      check("R6", "idiv released unit", main_unit, 32'h98);

      // R6: FP divide holds unit 12 for 11 decisions
      drive(1'b1, 8'h01, 16'h0003, 8'h01, 8'h00, 16'h0000, 8'h00);
      @(negedge clk);
      check("R6", "fdiv unit", main_unit, 32'hC);
      drive(1'b1, 8'h03, 16'h000F, 8'h00, 8'h00, 16'h0000, 8'h00);
      for (int k = 1; k <= 11; k++) begin
         @(negedge clk);
         check("R6", $sformatf("fdiv busy %0d gnt", k), {24'h0, main_gnt}, 32'h01);
         check("R6", $sformatf("fdiv busy %0d unit", k), main_unit, 32'hD);
      end
      @(negedge clk);
      check("R6", "fdiv released gnt", {24'h0, main_gnt}, 32'h03);
      check("R6", "fdiv released unit", main_unit, 32'hDC);

      // R8: reset frees a busy divider
      drive(1'b1, 8'h01, 16'h0001, 8'h01, 8'h00, 16'h0000, 8'h00);
      @(negedge clk);
      check("R8", "div before reset", main_unit, 32'h8);
      rst_n = 1'b0;
      #1;
      check("R8", "async clear", {24'h0, main_gnt}, 32'h0);
      @(negedge clk);
      rst_n = 1'b1;
      drive(1'b1, 8'h03, 16'h0005, 8'h00, 8'h00, 16'h0000, 8'h00);
      @(negedge clk);
      check("R8", "post-reset gnt", {24'h0, main_gnt}, 32'h03);
      check("R8", "post-reset unit", main_unit, 32'h98);

      summary();
      $finish;
   end

endmodule